// File: doc/BRIEF.md
# Processor Interrupt Entry Controller

This block sits beside a small 32-bit processor core and carries out the architectural entry sequence for interrupts. It looks at a reset request, a non-maskable request and six maskable request lines at each instruction boundary the core reports. When it accepts a request it captures the core's current program counter and status word into a shadow pair, updates a 32-bit cause register and hands the core a redirect: a new program counter and a new status word, valid for one cycle. The core then loads both and continues at the vector.

Non-maskable entries and maskable entries use separate shadow pairs. The cause register is split in two halves: the upper half holds the non-maskable cause and the lower half holds the maskable cause. A non-maskable request that arrives while one is already in service is remembered in a single pending flag. Further repeats are not counted. When the core signals the return from the non-maskable handler, the block redirects the core to the saved location and status. The remembered request is then taken at the first boundary where the in-service bit is clear.

Status-word bit positions used throughout: bit 5 is the interrupt-disable flag (ID), bit 6 is the exception-pending flag (EP), bit 7 is the non-maskable-in-service flag (NP).

Top module: `irq_entry_ctl`

## Requirements
- R1: A reset request accepted at a boundary redirects to PC 0x00000000 with status 0x00000020, clears the whole cause register and clears the pending flag.
- R2: Every entry (reset, non-maskable, maskable) presents a status word with bit 5 (ID) set and bit 6 (EP) clear.
- R3: A maskable request is accepted only when bit 5 of the incoming status word is 0. Reset and non-maskable requests are accepted whatever bit 5 holds.
- R4: A non-maskable entry, accepted only when bit 7 (NP) of the incoming status is 0, copies the PC and status into the non-maskable save pair. It sets bit 7 in the new status, writes 0x0010 into cause bits 31:16 while keeping bits 15:0, and redirects to 0x10.
- R5: A maskable entry for line i (i = 0..5) copies the PC and status into the maskable save pair and redirects to 0x80 + 0x10*i. It writes that same vector into cause bits 15:0 and keeps bits 31:16.
- R6: When several requests are present, the winner is chosen in this order: reset, then a return strobe, then a non-maskable request (live or pending), then maskable line 0 up to line 5.
- R7: A non-maskable request seen at a boundary while bit 7 of the incoming status is 1 sets the single pending flag. Repeats while it is set change nothing.
- R8: A pending non-maskable request is entered at the first accepted boundary where bit 7 of the incoming status is 0. Entering it clears the flag.
- R9: A return strobe redirects to the non-maskable saved PC and status, with the resume output high. It leaves the save pairs and the cause register unchanged.
- R10: Requests are looked at only in cycles with the boundary input high and no redirect on the outputs. A decision appears on the outputs one clock later, and the redirect output is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| boundary_i | input | 1 | Core is at an instruction boundary; requests are sampled |
| req_reset_i | input | 1 | Reset request, level |
| req_nmi_i | input | 1 | Non-maskable request, level |
| req_mask_i | input | 6 | Maskable request lines, level, bit i is line i |
| nmi_ret_i | input | 1 | Return-from-non-maskable-handler strobe |
| cur_pc_i | input | 32 | Core's current program counter |
| cur_psw_i | input | 32 | Core's current status word |
| redirect_o | output | 1 | One-cycle pulse: core must load next_pc_o and next_psw_o |
| resume_o | output | 1 | The current redirect is a return, not an entry |
| next_pc_o | output | 32 | Program counter to load, valid with redirect_o |
| next_psw_o | output | 32 | Status word to load, valid with redirect_o |
| cause_o | output | 32 | Cause register: 31:16 non-maskable, 15:0 maskable |
| fepc_o | output | 32 | Saved PC of the last non-maskable entry |
| fepsw_o | output | 32 | Saved status of the last non-maskable entry |
| eipc_o | output | 32 | Saved PC of the last maskable entry |
| eipsw_o | output | 32 | Saved status of the last maskable entry |
| nmi_pend_o | output | 1 | A non-maskable request is waiting |

## Verification
The bound checker watches several properties on every cycle. Every entry carries ID set and EP clear. The two save pairs move only on their own kind of entry. A maskable redirect always follows a cycle where the incoming ID bit was clear, and a reset redirect always carries the reset status with a clear cause. The pending flag rises only while NP was set, a return always presents the saved pair, and a redirect never lasts two cycles. What the properties cannot show is which request should have won in a given cycle and what values should have landed in the cause halves and save pairs. The bench covers this by running a reference model beside the block over directed sequences and random traffic. These include simultaneous requests, repeated non-maskable requests while one is in service, a return followed by the pending entry, and requests with the boundary low.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;

    // Outcome of one sampling decision.
    typedef enum logic [2:0] {
        EV_NONE   = 3'd0,
        EV_RESET  = 3'd1,
        EV_RESUME = 3'd2,
        EV_NMI    = 3'd3,
        EV_MASK   = 3'd4
    } irq_event_e;

endpackage

// File: rtl/irq_src_arbiter.sv
module irq_src_arbiter
    import irq_entry_pkg::*;
#(
    parameter int NUM_SRC = 6,
    parameter int IDX_W   = $clog2(NUM_SRC)
) (
    input  logic               sample_i,
    input  logic               busy_i,
    input  logic               ret_i,
    input  logic               req_reset_i,
    input  logic               req_nmi_i,
    input  logic               pend_i,
    input  logic [NUM_SRC-1:0] req_mask_i,
    input  logic               id_i,
    input  logic               np_i,
    output irq_event_e         event_o,
    output logic [IDX_W-1:0]   idx_o,
    output logic               pend_set_o
);

    logic found;

    // Lowest-numbered maskable line wins.
    always_comb begin
        found = 1'b0;
        idx_o = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (req_mask_i[i]) begin
                found = 1'b1;
                idx_o = IDX_W'(i);
            end
        end
    end

    always_comb begin
        event_o    = EV_NONE;
        pend_set_o = 1'b0;
        if (!busy_i) begin
            if (sample_i && req_reset_i) begin
                event_o = EV_RESET;
            end else begin
                if (ret_i) begin
                    event_o = EV_RESUME;
                end else if (sample_i && (req_nmi_i || pend_i) && !np_i) begin
                    event_o = EV_NMI;
                end else if (sample_i && found && !id_i) begin
                    event_o = EV_MASK;
                end
                pend_set_o = sample_i && req_nmi_i && np_i;
            end
        end
    end

endmodule

// File: rtl/irq_vec_table.sv
module irq_vec_table #(
    parameter int NUM_SRC  = 6,
    parameter int XLEN     = 32,
    parameter int VEC_BASE = 'h80,
    parameter int VEC_STEP = 'h10,
    parameter int IDX_W    = $clog2(NUM_SRC)
) (
    input  logic [IDX_W-1:0] idx_i,
    output logic [XLEN-1:0]  vec_o
);

    logic [XLEN-1:0] table_w [NUM_SRC];

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_vec
        assign table_w[g] = XLEN'(VEC_BASE + g * VEC_STEP);
    end

    always_comb begin
        vec_o = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (idx_i == IDX_W'(i)) begin
                vec_o = table_w[i];
            end
        end
    end

endmodule

// File: rtl/irq_entry_ctl.sv
module irq_entry_ctl
    import irq_entry_pkg::*;
#(
    parameter int XLEN      = 32,
    parameter int NUM_SRC   = 6,
    parameter int VEC_BASE  = 'h80,
    parameter int VEC_STEP  = 'h10,
    parameter int NMI_VEC   = 'h10,
    parameter int NMI_CODE  = 'h10,
    parameter int RESET_PSW = 'h20,
    parameter int ID_BIT    = 5,
    parameter int EP_BIT    = 6,
    parameter int NP_BIT    = 7
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               boundary_i,
    input  logic               req_reset_i,
    input  logic               req_nmi_i,
    input  logic [NUM_SRC-1:0] req_mask_i,
    input  logic               nmi_ret_i,
    input  logic [XLEN-1:0]    cur_pc_i,
    input  logic [XLEN-1:0]    cur_psw_i,
    output logic               redirect_o,
    output logic               resume_o,
    output logic [XLEN-1:0]    next_pc_o,
    output logic [XLEN-1:0]    next_psw_o,
    output logic [XLEN-1:0]    cause_o,
    output logic [XLEN-1:0]    fepc_o,
    output logic [XLEN-1:0]    fepsw_o,
    output logic [XLEN-1:0]    eipc_o,
    output logic [XLEN-1:0]    eipsw_o,
    output logic               nmi_pend_o
);

    localparam int              HALF   = XLEN / 2;
    localparam int              IDX_W  = $clog2(NUM_SRC);
    localparam logic [XLEN-1:0] ID_M   = XLEN'(1) << ID_BIT;
    localparam logic [XLEN-1:0] EP_M   = XLEN'(1) << EP_BIT;
    localparam logic [XLEN-1:0] NP_M   = XLEN'(1) << NP_BIT;

    typedef struct packed {
        logic            redir;
        logic            resume;
        logic [XLEN-1:0] pc;
        logic [XLEN-1:0] psw;
        logic [XLEN-1:0] cause;
        logic [XLEN-1:0] fepc;
        logic [XLEN-1:0] fepsw;
        logic [XLEN-1:0] eipc;
        logic [XLEN-1:0] eipsw;
        logic            pend;
    } ent_state_t;

    ent_state_t      st_d, st_q;
    irq_event_e      ev_w;
    logic [IDX_W-1:0] idx_w;
    logic            pend_set_w;
    logic [XLEN-1:0] vec_w;

    irq_src_arbiter #(
        .NUM_SRC (NUM_SRC),
        .IDX_W   (IDX_W)
    ) u_arb (
        .sample_i    (boundary_i),
        .busy_i      (st_q.redir),
        .ret_i       (nmi_ret_i),
        .req_reset_i (req_reset_i),
        .req_nmi_i   (req_nmi_i),
        .pend_i      (st_q.pend),
        .req_mask_i  (req_mask_i),
        .id_i        (cur_psw_i[ID_BIT]),
        .np_i        (cur_psw_i[NP_BIT]),
        .event_o     (ev_w),
        .idx_o       (idx_w),
        .pend_set_o  (pend_set_w)
    );

    irq_vec_table #(
        .NUM_SRC  (NUM_SRC),
        .XLEN     (XLEN),
        .VEC_BASE (VEC_BASE),
        .VEC_STEP (VEC_STEP),
        .IDX_W    (IDX_W)
    ) u_vec (
        .idx_i (idx_w),
        .vec_o (vec_w)
    );

    always_comb begin
        st_d        = st_q;
        st_d.redir  = 1'b0;
        st_d.resume = 1'b0;
        if (pend_set_w) begin
            st_d.pend = 1'b1;
        end
        unique case (ev_w)
            EV_RESET: begin
                st_d.redir = 1'b1;
                st_d.pc    = '0;
                st_d.psw   = XLEN'(RESET_PSW);
                st_d.cause = '0;
                st_d.pend  = 1'b0;
            end
            EV_RESUME: begin
                st_d.redir  = 1'b1;
                st_d.resume = 1'b1;
                st_d.pc     = st_q.fepc;
                st_d.psw    = st_q.fepsw;
            end
            EV_NMI: begin
                st_d.redir = 1'b1;
                st_d.pc    = XLEN'(NMI_VEC);
                st_d.psw   = (cur_psw_i | ID_M | NP_M) & ~EP_M;
                st_d.fepc  = cur_pc_i;
                st_d.fepsw = cur_psw_i;
                st_d.cause = {HALF'(NMI_CODE), st_q.cause[HALF-1:0]};
                st_d.pend  = 1'b0;
            end
            EV_MASK: begin
                st_d.redir = 1'b1;
                st_d.pc    = vec_w;
                st_d.psw   = (cur_psw_i | ID_M) & ~EP_M;
                st_d.eipc  = cur_pc_i;
                st_d.eipsw = cur_psw_i;
                st_d.cause = {st_q.cause[XLEN-1:HALF], vec_w[HALF-1:0]};
            end
            default: begin
            end
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign redirect_o = st_q.redir;
    assign resume_o   = st_q.resume;
    assign next_pc_o  = st_q.pc;
    assign next_psw_o = st_q.psw;
    assign cause_o    = st_q.cause;
    assign fepc_o     = st_q.fepc;
    assign fepsw_o    = st_q.fepsw;
    assign eipc_o     = st_q.eipc;
    assign eipsw_o    = st_q.eipsw;
    assign nmi_pend_o = st_q.pend;

endmodule

// File: rtl/irq_entry_chk.sv
module irq_entry_chk #(
    parameter int XLEN      = 32,
    parameter int NUM_SRC   = 6,
    parameter int VEC_BASE  = 'h80,
    parameter int NMI_VEC   = 'h10,
    parameter int RESET_PSW = 'h20,
    parameter int ID_BIT    = 5,
    parameter int EP_BIT    = 6,
    parameter int NP_BIT    = 7
) (
    input logic               clk_i,
    input logic               rst_ni,
    input logic               boundary_i,
    input logic               req_reset_i,
    input logic               req_nmi_i,
    input logic [NUM_SRC-1:0] req_mask_i,
    input logic               nmi_ret_i,
    input logic [XLEN-1:0]    cur_pc_i,
    input logic [XLEN-1:0]    cur_psw_i,
    input logic               redirect_o,
    input logic               resume_o,
    input logic [XLEN-1:0]    next_pc_o,
    input logic [XLEN-1:0]    next_psw_o,
    input logic [XLEN-1:0]    cause_o,
    input logic [XLEN-1:0]    fepc_o,
    input logic [XLEN-1:0]    fepsw_o,
    input logic [XLEN-1:0]    eipc_o,
    input logic [XLEN-1:0]    eipsw_o,
    input logic               nmi_pend_o
);

    p_entry_flags_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (redirect_o && !resume_o) |-> (next_psw_o[ID_BIT] && !next_psw_o[EP_BIT]));

    p_redirect_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        redirect_o |=> !redirect_o);

    p_fepc_only_on_nmi_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(fepc_o) |-> (redirect_o && !resume_o && next_pc_o == XLEN'(NMI_VEC)
                              && next_psw_o[NP_BIT]));

    p_eipc_only_on_mask_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(eipc_o) |-> (redirect_o && !resume_o && next_pc_o >= XLEN'(VEC_BASE)));

    p_mask_needs_id_clear_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (redirect_o && !resume_o && next_pc_o >= XLEN'(VEC_BASE)) |-> !$past(cur_psw_i[ID_BIT]));

    p_reset_entry_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (redirect_o && !resume_o && next_pc_o == '0) |->
            (cause_o == '0 && next_psw_o == XLEN'(RESET_PSW) && !nmi_pend_o));

    p_pend_needs_np_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(nmi_pend_o) |-> $past(cur_psw_i[NP_BIT]));

    p_resume_restores_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        resume_o |-> (redirect_o && next_pc_o == fepc_o && next_psw_o == fepsw_o));

endmodule

bind irq_entry_ctl irq_entry_chk #(
    .XLEN      (XLEN),
    .NUM_SRC   (NUM_SRC),
    .VEC_BASE  (VEC_BASE),
    .NMI_VEC   (NMI_VEC),
    .RESET_PSW (RESET_PSW),
    .ID_BIT    (ID_BIT),
    .EP_BIT    (EP_BIT),
    .NP_BIT    (NP_BIT)
) u_chk (.*);

// File: tb/tb_irq_entry_ctl.sv
module tb_irq_entry_ctl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bnd = 1'b0, rreq = 1'b0, nreq = 1'b0, nret = 1'b0;
    logic [5:0]  mreq = '0;
    logic [31:0] cpc = 32'h100, cpsw = 32'h20;
    logic        redirect, resume, pend;
    logic [31:0] npc, npsw, cause, fepc, fepsw, eipc, eipsw;

    int total = 0, bad = 0;
    bit done = 0;

    // reference model state (what the block should hold after the last edge)
    logic        m_redir = 0, m_resume = 0, m_pend = 0;
    logic [31:0] m_pc = 0, m_psw = 0, m_cause = 0;
    logic [31:0] m_fepc = 0, m_fepsw = 0, m_eipc = 0, m_eipsw = 0;
    string       m_tag = "R10 reset state";

    localparam logic [31:0] IDM = 32'h20, EPM = 32'h40, NPM = 32'h80;

    always #10 clk = ~clk;

    irq_entry_ctl dut (
        .clk_i(clk), .rst_ni(rst_n), .boundary_i(bnd), .req_reset_i(rreq),
        .req_nmi_i(nreq), .req_mask_i(mreq), .nmi_ret_i(nret),
        .cur_pc_i(cpc), .cur_psw_i(cpsw), .redirect_o(redirect), .resume_o(resume),
        .next_pc_o(npc), .next_psw_o(npsw), .cause_o(cause), .fepc_o(fepc),
        .fepsw_o(fepsw), .eipc_o(eipc), .eipsw_o(eipsw), .nmi_pend_o(pend)
    );

    task automatic chk(input string tag, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] vec_of(input int i);
        return 32'h80 + 32'h10 * i;
    endfunction

    // Model of one sampling edge, from the requirements.
    task automatic model_edge();
        logic busy, nmi_e, hit;
        int   idx, nreqs;
        busy = m_redir;
        m_redir = 0; m_resume = 0;
        m_tag = "R10 idle";
        if (busy || !bnd) begin
            if (!busy && nret) begin
                m_redir = 1; m_resume = 1; m_pc = m_fepc; m_psw = m_fepsw;
                m_tag = "R9 return";
            end
            return;
        end
        nreqs = int'(rreq) + int'(nreq | m_pend) + int'(nret) + int'(mreq != 0);
        if (rreq) begin
            m_redir = 1; m_pc = 0; m_psw = 32'h20; m_cause = 0; m_pend = 0;
            m_tag = (nreqs > 1) ? "R6 reset wins" : "R1 reset entry";
            return;
        end
        hit = 0; idx = 0;
        for (int i = 5; i >= 0; i--) if (mreq[i]) begin hit = 1; idx = i; end
        nmi_e = nreq | m_pend;
        if (nret) begin
            m_redir = 1; m_resume = 1; m_pc = m_fepc; m_psw = m_fepsw;
            m_tag = (nreqs > 1) ? "R6 return wins" : "R9 return";
        end else if (nmi_e && !cpsw[7]) begin
            m_redir = 1; m_pc = 32'h10; m_psw = (cpsw | IDM | NPM) & ~EPM;
            m_fepc = cpc; m_fepsw = cpsw; m_cause = {16'h0010, m_cause[15:0]};
            m_tag = m_pend ? "R8 pending nmi taken" : ((nreqs > 1) ? "R6 nmi wins" : "R4 nmi entry");
            m_pend = 0;
        end else if (hit && !cpsw[5]) begin
            m_redir = 1; m_pc = vec_of(idx); m_psw = (cpsw | IDM) & ~EPM;
            m_eipc = cpc; m_eipsw = cpsw; m_cause = {m_cause[31:16], vec_of(idx)[15:0]};
            m_tag = ($countones(mreq) > 1) ? "R6 lowest line wins" : "R5 maskable entry";
        end else if (hit) begin
            m_tag = "R3 maskable blocked by ID";
        end
        if (nreq && cpsw[7]) begin
            m_tag = m_pend ? "R7 repeat nmi dropped" : "R7 nmi pending";
            m_pend = 1;
        end
    endtask

    // One cycle: check, let the core apply a redirect, drive inputs, predict.
    task automatic step(input bit rnd, input logic b, input logic r, input logic n,
                        input logic [5:0] m, input logic t, input bit ovr,
                        input logic [31:0] ovr_psw);
        string tg;
        @(negedge clk);
        tg = m_tag;
        chk(tg, "redirect (R10)", 32'(redirect), 32'(m_redir));
        chk(tg, "resume (R9)", 32'(resume), 32'(m_resume));
        if (m_redir) begin
            chk(tg, "next_pc", npc, m_pc);
            chk(m_resume ? tg : {"R2 ", tg}, "next_psw", npsw, m_psw);
        end
        chk(tg, "cause", cause, m_cause);
        chk(tg, "fepc", fepc, m_fepc);
        chk(tg, "fepsw", fepsw, m_fepsw);
        chk(tg, "eipc", eipc, m_eipc);
        chk(tg, "eipsw", eipsw, m_eipsw);
        chk(tg, "pending (R7)", 32'(pend), 32'(m_pend));
        // core model
        if (m_redir) begin
            cpc = m_pc; cpsw = m_psw;
        end else if (rnd) begin
            if (bnd) cpc = cpc + 4;
            if ($urandom % 8 == 0) cpsw[5] = ~cpsw[5];
            if ($urandom % 16 == 0) cpsw[6] = 1'b1;
        end
        if (ovr) cpsw = ovr_psw;
        bnd = b; rreq = r; nreq = n; mreq = m; nret = t;
        model_edge();
    endtask

    task automatic idle(input int k);
        for (int i = 0; i < k; i++) step(0, 0, 0, 0, 6'h0, 0, 0, 0);
    endtask

    initial begin
        void'($urandom(32'h5eed1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // reset state is checked by the first step
        idle(2);
        // R3: all lines raised with ID set: nothing happens
        step(0, 1, 0, 0, 6'h3f, 0, 0, 0);
        idle(2);
        // R5/R6: ID clear, lines 2,3,5 -> line 2, vector 0xA0
        step(0, 1, 0, 0, 6'b101100, 0, 1, 32'h0000_0040);
        idle(3);
        // R6: NMI beats maskable, ID clear
        step(0, 1, 0, 1, 6'h01, 0, 1, 32'h0);
        idle(2);
        // R7: NMI while NP set (core now holds NP) -> pending, repeat dropped
        step(0, 1, 0, 1, 6'h0, 0, 0, 0);
        step(0, 1, 0, 1, 6'h0, 0, 0, 0);
        // R10: boundary low, requests ignored
        step(0, 0, 1, 1, 6'h3f, 0, 0, 0);
        idle(1);
        // R9: return, then R8: pending taken at next boundary
        step(0, 0, 0, 0, 6'h0, 1, 0, 0);
        idle(2);
        step(0, 1, 0, 0, 6'h0, 0, 0, 0);
        idle(2);
        // R10: a request during the redirect cycle is ignored
        step(0, 1, 0, 0, 6'h0, 1, 0, 0);
        step(0, 1, 1, 0, 6'h0, 0, 0, 0);
        idle(2);
        // R1/R6: reset beats everything
        step(0, 1, 1, 1, 6'h3f, 1, 1, 32'h80);
        idle(2);
        // random traffic
        for (int c = 0; c < 6000; c++) begin
            logic b, r, n, t;
            logic [5:0] m;
            b = ($urandom % 10) < 7;
            r = ($urandom % 300) == 0;
            n = ($urandom % 12) == 0;
            m = 6'($urandom & $urandom & $urandom);
            t = cpsw[7] && (($urandom % 8) == 0);
            step(1, b, r, n, m, t, 0, 0);
        end
        idle(2);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL R10 watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule